// File: doc/BRIEF.md
# Scaling Accumulator Serial Multiplier

This block multiplies a signed two's-complement operand that arrives one bit per clock by a signed coefficient that is presented in parallel. It is meant as a small, slow gain stage in an audio path, where one product per sample period is enough and area matters more than latency. A single accumulator collects one partial product per serial bit. The coefficient is added when the bit is one. It is subtracted instead when the bit is the operand's sign bit. The weight of each bit is set by rescaling the accumulator every step, not by shifting the coefficient.

A one-cycle start pulse captures the coefficient and clears the accumulator. The serial operand then follows on the next SER_W clocks. One cycle after the last bit, the full-precision product appears on a parallel port, together with a one-cycle valid strobe. A truncated copy is also provided, made of the top TRIM_W product bits. The arrival order of the serial bits is fixed at build time by a parameter. With LSB-first order the accumulator is halved before each add. With MSB-first order it is doubled. Both orders use the same adder and the same coefficient register.

Top module: `scaling_serial_mult`

## Requirements
- R1: After reset, validOut is 0 and productOut is 0.
- R2: A start pulse clears the accumulator and captures coefIn. serIn is sampled on each of the SER_W clock edges that follow the start edge, one operand bit per edge.
- R3: On the edge that consumes the last serial bit, productOut becomes the exact signed product of the operand and the captured coefficient, PROD_W = SER_W + COEF_W bits wide. validOut is 1 for exactly the one cycle after that edge.
- R4: With MSB_FIRST = 0, the first serial bit has weight 2^0 and the last bit is the sign bit, with weight -2^(SER_W-1).
- R5: With MSB_FIRST = 1, the first serial bit is the sign bit, with weight -2^(SER_W-1), and the last bit has weight 2^0.
- R6: Changes on coefIn after the start edge have no effect on the product being formed.
- R7: productOut holds its value from the valid cycle until the next start pulse.
- R8: trimOut equals the top TRIM_W bits of productOut, which is floor(product / 2^(PROD_W-TRIM_W)).
- R9: A start pulse during a multiply abandons it. The new multiply then runs in full, and no valid strobe is given for the abandoned one.
- R10: Products of extreme operands are exact, including most-negative times most-negative (+2^(PROD_W-2)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a multiply; captures coefIn |
| serIn | input | 1 | Serial operand bit |
| coefIn | input | COEF_W | Signed parallel coefficient |
| productOut | output | PROD_W | Signed full-precision product |
| trimOut | output | TRIM_W | Truncated product (top bits) |
| validOut | output | 1 | One-cycle strobe: product ready |

## Verification
Take the start pulse as sampled on edge 0. Operand bits are consumed on edges 1 to SER_W. Both the product and the valid strobe therefore change on edge SER_W, and they are visible in the cycle after it. The valid strobe drops again on the next edge. A behavioural model, driven by the same inputs, updates at each rising edge and decides in which cycle valid is expected. The bench compares valid, the product and the truncated product at every falling edge. It checks the product only while the model is idle, which means after reset or after a completed multiply, when the expected value is defined. A second instance built MSB-first receives the same stream and is compared in the same cycles.

// File: rtl/sam_pkg.sv
package sam_pkg;
  typedef struct packed {
    logic clear;
    logic step;
    logic signStep;
  } samCtl_t;
endpackage

// File: rtl/sam_ctrl.sv
module sam_ctrl
  import sam_pkg::*;
#(
  parameter int SER_W = 20,
  parameter bit MSB_FIRST = 1'b0
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output samCtl_t ctl,
  output logic    done
);
  localparam int CNT_W = (SER_W > 1) ? $clog2(SER_W) : 1;

  logic             busy;
  logic [CNT_W-1:0] bitCnt;
  logic             lastBit;
  logic             firstBit;

  assign lastBit  = (bitCnt == CNT_W'(SER_W - 1));
  assign firstBit = (bitCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      bitCnt <= '0;
      done   <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      bitCnt <= '0;
      done   <= 1'b0;
    end else if (busy) begin
      done <= lastBit;
      if (lastBit) begin
        busy   <= 1'b0;
        bitCnt <= '0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  generate
    if (MSB_FIRST) begin : g_signFirst
      assign ctl.signStep = busy && firstBit;
    end else begin : g_signLast
      assign ctl.signStep = busy && lastBit;
    end
  endgenerate

  assign ctl.clear = start;
  assign ctl.step  = busy && !start;
endmodule

// File: rtl/sam_dp.sv
module sam_dp
  import sam_pkg::*;
#(
  parameter int SER_W = 20,
  parameter int COEF_W = 16,
  parameter bit MSB_FIRST = 1'b0,
  localparam int PROD_W = SER_W + COEF_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  samCtl_t                  ctl,
  input  logic                     serIn,
  input  logic signed [COEF_W-1:0] coefIn,
  output logic signed [COEF_W-1:0] coefQ,
  output logic signed [PROD_W-1:0] acc
);
  logic signed [PROD_W-1:0] coefExt;
  logic signed [PROD_W-1:0] term;
  logic signed [PROD_W-1:0] accNext;

  assign coefExt = PROD_W'(coefQ);

  always_comb begin
    if (!serIn)            term = '0;
    else if (ctl.signStep) term = -coefExt;
    else                   term = coefExt;
  end

  generate
    if (MSB_FIRST) begin : g_double
      assign accNext = (acc <<< 1) + term;
    end else begin : g_halve
      assign accNext = (acc >>> 1) + (term <<< (SER_W - 1));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coefQ <= '0;
      acc   <= '0;
    end else if (ctl.clear) begin
      coefQ <= coefIn;
      acc   <= '0;
    end else if (ctl.step) begin
      acc <= accNext;
    end
  end
endmodule

// File: rtl/scaling_serial_mult.sv
module scaling_serial_mult
  import sam_pkg::*;
#(
  parameter int SER_W = 20,
  parameter int COEF_W = 16,
  parameter int TRIM_W = 16,
  parameter bit MSB_FIRST = 1'b0,
  localparam int PROD_W = SER_W + COEF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              serIn,
  input  logic [COEF_W-1:0] coefIn,
  output logic [PROD_W-1:0] productOut,
  output logic [TRIM_W-1:0] trimOut,
  output logic              validOut
);
  samCtl_t                  ctl;
  logic signed [COEF_W-1:0] coefHeld;
  logic signed [PROD_W-1:0] accQ;

  sam_ctrl #(.SER_W(SER_W), .MSB_FIRST(MSB_FIRST)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .ctl(ctl), .done(validOut)
  );

  sam_dp #(.SER_W(SER_W), .COEF_W(COEF_W), .MSB_FIRST(MSB_FIRST)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .serIn(serIn),
    .coefIn(coefIn), .coefQ(coefHeld), .acc(accQ)
  );

  assign productOut = accQ;
  assign trimOut    = accQ[PROD_W-1 -: TRIM_W];
endmodule

// File: rtl/sam_chk.sv
module sam_chk #(
  parameter int SER_W = 20,
  parameter int COEF_W = 16,
  parameter int PROD_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              validOut,
  input logic [PROD_W-1:0] productOut,
  input logic [COEF_W-1:0] coefHeld
);
  localparam int SC_W = $clog2(SER_W + 2) + 1;
  logic [SC_W-1:0] sinceStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceStart <= '1;
    else if (start)            sinceStart <= '0;
    else if (sinceStart != '1) sinceStart <= sinceStart + 1'b1;
  end

  // R3
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    validOut |=> !validOut);
  // R3
  valid_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> (sinceStart == SC_W'(SER_W)));
  // R2
  clear_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (productOut == '0) && !validOut);
  // R7
  hold_product_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && !start) |=> $stable(productOut));
  // R6
  coef_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> $stable(coefHeld));
endmodule

bind scaling_serial_mult sam_chk #(.SER_W(SER_W), .COEF_W(COEF_W), .PROD_W(PROD_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .validOut(validOut),
  .productOut(productOut), .coefHeld(coefHeld)
);

// File: tb/scaling_serial_mult_bench.sv
module scaling_serial_mult_bench;
  localparam int SER_W = 20;
  localparam int COEF_W = 16;
  localparam int TRIM_W = 16;
  localparam int PROD_W = SER_W + COEF_W;
  localparam int SH = PROD_W - TRIM_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, start = 1'b0, serIn = 1'b0;
  logic [COEF_W-1:0] coefIn = '0;
  logic [PROD_W-1:0] prodL, prodM;
  logic [TRIM_W-1:0] trimL, trimM;
  logic validL, validM;

  scaling_serial_mult #(.SER_W(SER_W), .COEF_W(COEF_W), .TRIM_W(TRIM_W), .MSB_FIRST(1'b0))
    u_scaling_serial_mult (.clk(clk), .rstN(rstN), .start(start), .serIn(serIn),
      .coefIn(coefIn), .productOut(prodL), .trimOut(trimL), .validOut(validL));

  scaling_serial_mult #(.SER_W(SER_W), .COEF_W(COEF_W), .TRIM_W(TRIM_W), .MSB_FIRST(1'b1))
    u_scaling_serial_mult_msb (.clk(clk), .rstN(rstN), .start(start), .serIn(serIn),
      .coefIn(coefIn), .productOut(prodM), .trimOut(trimM), .validOut(validM));

  int vecs = 0, bad = 0, cycles = 0;
  bit compareOn = 1'b0;
  string curReq = "R1";

  // behavioural reference
  bit mBusy = 1'b0, expValid = 1'b0;
  int mCnt = 0;
  logic [SER_W-1:0] lsbBits, msbBits;
  logic signed [COEF_W-1:0] mCoef;
  longint expL = 0, expM = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 1'b0; expValid = 1'b0; expL = 0; expM = 0;
    end else if (start) begin
      mBusy = 1'b1; mCnt = 0; mCoef = $signed(coefIn);
      expL = 0; expM = 0; expValid = 1'b0;
    end else if (mBusy) begin
      lsbBits[mCnt] = serIn;
      msbBits[SER_W-1-mCnt] = serIn;
      mCnt++;
      expValid = 1'b0;
      if (mCnt == SER_W) begin
        mBusy = 1'b0;
        expValid = 1'b1;
        expL = longint'($signed(lsbBits)) * longint'(mCoef);
        expM = longint'($signed(msbBits)) * longint'(mCoef);
      end
    end else begin
      expValid = 1'b0;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (compareOn) begin
      chk("R3 valid", longint'(validL), longint'(expValid));
      chk("R5 valid", longint'(validM), longint'(expValid));
      if (!mBusy) begin
        chk(curReq, longint'($signed(prodL)), expL);
        chk("R8", longint'($signed(trimL)), expL >>> SH);
        chk("R5", longint'($signed(prodM)), expM);
        chk("R8 msb", longint'($signed(trimM)), expM >>> SH);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  task automatic run(input logic [SER_W-1:0] s, input logic [COEF_W-1:0] c,
                     input string tag, input int abortAt, input bit wiggle);
    @(negedge clk);
    curReq = tag;
    start = 1'b1; coefIn = c; serIn = 1'b0;
    for (int k = 0; k < SER_W; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (abortAt != 0 && k == abortAt) return;
      serIn = s[k];
      if (wiggle) coefIn = ~coefIn ^ COEF_W'(k * 977);
    end
    @(negedge clk);
    serIn = 1'b0;
    @(negedge clk);
    curReq = "R7";
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", longint'(validL), 0);
    chk("R1 product", longint'($signed(prodL)), 0);
    chk("R1 msb product", longint'($signed(prodM)), 0);
    rstN = 1'b1;
    compareOn = 1'b1;
    @(negedge clk);
    run(20'd3, 16'd5, "R3", 0, 1'b0);
    run(20'd1, -16'sd7, "R4", 0, 1'b0);
    run(20'h80000, 16'd3, "R4", 0, 1'b0);
    run(20'hFFFFF, 16'd1234, "R3", 0, 1'b0);
    run(20'h00000, 16'h7ABC, "R3", 0, 1'b0);
    run(20'hA5C3E, -16'sd12345, "R2", 0, 1'b0);
    run(20'h80000, 16'h8000, "R10", 0, 1'b0);
    run(20'h7FFFF, 16'h7FFF, "R10", 0, 1'b0);
    run(20'h7FFFF, 16'h8000, "R10", 0, 1'b0);
    run(20'h13579, 16'h0F0F, "R6", 0, 1'b1);
    run(20'hFFFFF, 16'h4321, "R9", 7, 1'b0);
    run(20'h2468A, -16'sd300, "R9", 0, 1'b0);
    for (int i = 0; i < 6; i++)
      run(SER_W'(32'h9E3779B9 * (i + 3)), COEF_W'(32'h85EBCA6B * (i + 1)), "R8", 0, 1'b0);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule